// File: doc/BRIEF.md
# Wrapping Tenth-Second Elapsed Timer

This block measures elapsed time in tenths of a second from a single system clock. A prescaler turns the clock into a one-cycle strobe every `CLK_PER_TICK` cycles. The default of 5,000,000 cycles gives 100 ms at 50 MHz. On each strobe a decimal counter kept as BCD digits advances by one. When it has shown `TOP_VALUE` for a full period, it returns to zero and starts again.

The display side registers what the counter holds and presents it as BCD digits. The digits go with a blank flag and an error flag. The seven-segment decoding that follows is outside this block. Three controls act on the presented value only and never on the running count:
- A freeze input holds the last value on the output.
- A low enable blanks the output.
- A nonzero 2-bit error code replaces the time with an error indication.

Top module: `decisec_timer`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the count, the prescaler and the frozen snapshot clear. From the first edge after that, `o_digits`, `o_blank`, `o_error` and `o_err_code` are all zero.
- R2: The count rises by exactly one every `CLK_PER_TICK` clock cycles. After reset release, the shown value at edge j (j ≥ 1) is floor((j−1)/`CLK_PER_TICK`) modulo (`TOP_VALUE`+1).
- R3: On the strobe that arrives while the count equals `TOP_VALUE`, the count returns to zero.
- R4: Every value from 0 up to and including `TOP_VALUE` stays on `o_digits` for exactly `CLK_PER_TICK` consecutive cycles during free running.
- R5: `o_digits` carries BCD. Digit i occupies bits [4i+3:4i], the least significant digit sits at [3:0], and each digit is at most 9. A digit that passes 9 returns to 0 and carries into the next one.
- R6: All outputs are registered. A change of the count or of any control input reaches the outputs one clock edge later, and not before that edge.
- R7: While `i_freeze` is high, `o_digits` keeps the value it showed when freeze was first sampled, and the count keeps running. One edge after freeze drops, the live count appears.
- R8: An edge that samples `i_enable` low sets `o_blank`, forces `o_digits` to zero, and forces `o_error` and `o_err_code` to zero whatever the error code is.
- R9: An edge that samples `i_enable` high with a nonzero `i_err_code` sets `o_error`, copies the code to `o_err_code`, and forces `o_digits` to zero. A code of 0 gives no error, and the time shows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| i_enable | input | 1 | Display enable; low blanks the output |
| i_freeze | input | 1 | High holds the presented digits |
| i_err_code | input | 2 | Error selector; 0 means no error |
| o_digits | output | 4*DIGITS | BCD time digits, least significant in [3:0] |
| o_blank | output | 1 | Display is blanked |
| o_error | output | 1 | Error indication replaces the time |
| o_err_code | output | 2 | Error code being indicated |

## Verification
Every result of this block is due one rising edge after the stimulus or count change that causes it. The bench therefore drives inputs and samples outputs on falling edges. It compares each sample against a value computed from the number of edges seen since reset, so the expected value is tied to the exact edge where the count and the output register update. The latency check first samples the outputs before that edge, to show the new control value has not yet arrived, and then samples again on the next falling edge. The freeze, blank and error checks take their expected hold or replacement value at the falling edge where the control is applied. They compare every following cycle against it.

// File: rtl/decisec_pkg.sv
package decisec_pkg;

  typedef logic [3:0] bcd_t;

  // Binary to packed BCD, up to eight digits, least significant digit low.
  function automatic logic [31:0] to_bcd32(input int unsigned v);
    logic [31:0] r;
    int unsigned x;
    r = '0;
    x = v;
    for (int i = 0; i < 8; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  // Packed BCD back to binary.
  function automatic int unsigned from_bcd32(input logic [31:0] b);
    int unsigned r;
    r = 0;
    for (int i = 7; i >= 0; i--) begin
      r = r * 10 + int'(b[4*i +: 4]);
    end
    return r;
  endfunction

  // Next value of one decimal digit.
  function automatic bcd_t bcd_step(input bcd_t d);
    return (d == 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

endpackage

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
  parameter int CLK_PER_TICK = 5_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic o_tick
);
  localparam int CNT_W = (CLK_PER_TICK > 2) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_PER_TICK - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign o_tick = (cnt == LAST);

  // R2: the strobe lasts one cycle only
  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    o_tick |=> !o_tick);
  // R2: the prescaler never leaves its range
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/dt_bcd_counter.sv
module dt_bcd_counter
  import decisec_pkg::*;
#(
  parameter int DIGITS    = 4,
  parameter int TOP_VALUE = 132
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                i_tick,
  output logic [4*DIGITS-1:0] o_value,
  output logic                o_wrap
);
  localparam int W = 4 * DIGITS;
  localparam logic [W-1:0] TOP_BCD = W'(to_bcd32(TOP_VALUE));

  logic              at_top;
  logic [DIGITS-1:0] carry_in;

  assign at_top      = (o_value == TOP_BCD);
  assign o_wrap      = i_tick && at_top;
  assign carry_in[0] = i_tick;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_t dig_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        dig_q <= '0;
      end else if (o_wrap) begin
        dig_q <= '0;
      end else if (carry_in[g]) begin
        dig_q <= bcd_step(dig_q);
      end
    end

    assign o_value[4*g +: 4] = dig_q;

    if (g + 1 < DIGITS) begin : g_carry
      assign carry_in[g+1] = carry_in[g] && (dig_q == 4'd9);
    end

    // R5: each digit stays a decimal digit
    p_digit_bcd_r5: assert property (@(posedge clk) disable iff (rst)
      dig_q <= 4'd9);
  end

  // R2: a strobe below the top raises the binary value by one
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (i_tick && !at_top) |=>
      from_bcd32(32'(o_value)) == from_bcd32(32'($past(o_value))) + 1);
  // R3: a strobe at the top returns to zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    o_wrap |=> (o_value == '0));
  // R4: without a strobe the value dwells
  p_dwell_r4: assert property (@(posedge clk) disable iff (rst)
    !i_tick |=> $stable(o_value));
  // R3: the count never passes the top
  p_range_r3: assert property (@(posedge clk) disable iff (rst)
    from_bcd32(32'(o_value)) <= TOP_VALUE);
endmodule

// File: rtl/dt_display_reg.sv
module dt_display_reg #(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [4*DIGITS-1:0] i_live,
  input  logic                i_enable,
  input  logic                i_freeze,
  input  logic [1:0]          i_err_code,
  output logic [4*DIGITS-1:0] o_digits,
  output logic                o_blank,
  output logic                o_error,
  output logic [1:0]          o_err_code
);
  logic [4*DIGITS-1:0] snap_q;
  logic                blank_q;
  logic                err_q;
  logic [1:0]          code_q;
  logic                err_req;

  assign err_req = i_enable && (i_err_code != 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      blank_q <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= 2'd0;
    end else begin
      if (!i_freeze) begin
        snap_q <= i_live;
      end
      blank_q <= !i_enable;
      err_q   <= err_req;
      code_q  <= err_req ? i_err_code : 2'd0;
    end
  end

  assign o_digits   = (blank_q || err_q) ? '0 : snap_q;
  assign o_blank    = blank_q;
  assign o_error    = err_q;
  assign o_err_code = code_q;

  // R7: a frozen snapshot keeps its value
  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (rst)
    i_freeze |=> $stable(snap_q));
  // R6: an unfrozen snapshot follows the count one edge later
  p_follow_r6: assert property (@(posedge clk) disable iff (rst)
    !i_freeze |=> (snap_q == $past(i_live)));
  // R8: disable blanks the output and masks the error
  p_blank_r8: assert property (@(posedge clk) disable iff (rst)
    !i_enable |=> (o_blank && !o_error && o_err_code == 2'd0 && o_digits == '0));
  // R9: a nonzero code while enabled is indicated
  p_error_r9: assert property (@(posedge clk) disable iff (rst)
    (i_enable && i_err_code != 2'd0) |=>
      (o_error && o_err_code == $past(i_err_code) && o_digits == '0));
endmodule

// File: rtl/decisec_timer.sv
module decisec_timer #(
  parameter int CLK_PER_TICK = 5_000_000,
  parameter int TOP_VALUE    = 132,
  parameter int DIGITS       = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                i_enable,
  input  logic                i_freeze,
  input  logic [1:0]          i_err_code,
  output logic [4*DIGITS-1:0] o_digits,
  output logic                o_blank,
  output logic                o_error,
  output logic [1:0]          o_err_code
);
  logic                tick;
  logic                wrap_evt;
  logic [4*DIGITS-1:0] live_value;

  dt_prescaler #(
    .CLK_PER_TICK(CLK_PER_TICK)
  ) u_presc (
    .clk    (clk),
    .rst    (rst),
    .o_tick (tick)
  );

  dt_bcd_counter #(
    .DIGITS   (DIGITS),
    .TOP_VALUE(TOP_VALUE)
  ) u_count (
    .clk     (clk),
    .rst     (rst),
    .i_tick  (tick),
    .o_value (live_value),
    .o_wrap  (wrap_evt)
  );

  dt_display_reg #(
    .DIGITS(DIGITS)
  ) u_disp (
    .clk        (clk),
    .rst        (rst),
    .i_live     (live_value),
    .i_enable   (i_enable),
    .i_freeze   (i_freeze),
    .i_err_code (i_err_code),
    .o_digits   (o_digits),
    .o_blank    (o_blank),
    .o_error    (o_error),
    .o_err_code (o_err_code)
  );

  // R3: after a wrap the live count is zero
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (live_value == '0));
endmodule

// File: tb/decisec_timer_test.sv
module decisec_timer_test;
  localparam int N   = 3;
  localparam int TOP = 105;
  localparam int D   = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b1;
  logic          fr  = 1'b0;
  logic [1:0]    err = 2'd0;
  logic [4*D-1:0] dig;
  logic          blank, error;
  logic [1:0]    code;

  int total = 0;
  int bad   = 0;
  int j     = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  decisec_timer #(.CLK_PER_TICK(N), .TOP_VALUE(TOP), .DIGITS(D)) uut (
    .clk(clk), .rst(rst), .i_enable(en), .i_freeze(fr), .i_err_code(err),
    .o_digits(dig), .o_blank(blank), .o_error(error), .o_err_code(code));

  always @(posedge clk) begin
    if (rst) j <= 0;
    else     j <= j + 1;
  end

  function automatic int exp_val(input int jj);
    return (jj == 0) ? 0 : ((jj - 1) / N) % (TOP + 1);
  endfunction

  function automatic logic [4*D-1:0] bcd(input int v);
    logic [4*D-1:0] r;
    int x;
    x = v;
    for (int i = 0; i < D; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4*D-1:0] prev;
    int run;
    int held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dig == '0, "R1 digits", 32'(dig), 0);
    check(!blank && !error && code == 2'd0, "R1 flags",
          {blank, error, code}, 0);
    rst = 1'b0;

    // Sweep two laps: R2 value, R3 wrap, R4 dwell, R5 digit coding
    prev = 'x;
    run  = 0;
    for (int c = 0; c < 2 * (TOP + 1) * N + 4; c++) begin
      @(negedge clk);
      check(dig == bcd(exp_val(j)), "R2 count", 32'(dig), 32'(bcd(exp_val(j))));
      for (int i = 0; i < D; i++)
        check(dig[4*i +: 4] <= 4'd9, "R5 digit", 32'(dig[4*i +: 4]), 9);
      if (c > 0 && dig == prev) begin
        run++;
      end else begin
        if (c > 0) begin
          check(run == N, "R4 dwell", run, N);
          if (prev == bcd(TOP))
            check(dig == '0, "R3 wrap", 32'(dig), 0);
        end
        prev = dig;
        run  = 1;
      end
    end

    // R6 latency and R8 blanking with error masked
    en = 1'b0;
    err = 2'd2;
    #1;
    check(!blank, "R6 before edge", blank, 0);
    @(negedge clk);
    check(blank && dig == '0, "R8 blank", {blank, dig}, {1'b1, 16'h0});
    check(!error && code == 2'd0, "R8 error masked", {error, code}, 0);
    // R9 error codes
    for (int e = 1; e < 4; e++) begin
      en = 1'b1;
      err = 2'(e);
      @(negedge clk);
      check(error && code == 2'(e) && dig == '0 && !blank, "R9 error",
            {blank, error, code, dig}, {1'b0, 1'b1, 2'(e), 16'h0});
    end
    err = 2'd0;
    @(negedge clk);
    check(!error && dig == bcd(exp_val(j)), "R9 clear", 32'(dig),
          32'(bcd(exp_val(j))));

    // R7 freeze holds while the count runs on, even through an error
    held = exp_val(j);
    fr = 1'b1;
    for (int c = 0; c < 3 * N + 2; c++) begin
      @(negedge clk);
      if (c == 2) err = 2'd1;
      if (c == 3) err = 2'd0;
      if (c != 3)
        check(dig == bcd(held), "R7 hold", 32'(dig), 32'(bcd(held)));
    end
    fr = 1'b0;
    #1;
    check(dig == bcd(held), "R6 freeze release lag", 32'(dig), 32'(bcd(held)));
    @(negedge clk);
    check(dig == bcd(exp_val(j)), "R7 resume", 32'(dig), 32'(bcd(exp_val(j))));

    // R1 reset mid-run
    rst = 1'b1;
    en = 1'b0;
    @(negedge clk);
    check(dig == '0 && !blank && !error, "R1 mid reset",
          {blank, error, dig}, 0);
    en = 1'b1;
    rst = 1'b0;
    for (int c = 0; c < 4 * N; c++) begin
      @(negedge clk);
      check(dig == bcd(exp_val(j)), "R2 restart", 32'(dig), 32'(bcd(exp_val(j))));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule